// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides whether the frame now arriving should be kept. It watches the first six bytes of each frame, which hold the destination address. A frame is kept when any enabled path agrees:

- the address equals the station's own address;
- the address is broadcast;
- the address is a group address whose hash lands on a set bit of a 64-entry table;
- promiscuous mode is on.

The hash is a CRC-32 run over the six address bytes as they arrive, one byte per accepted beat. Six bits of the final CRC pick one of 64 table bits. The table is held as two 32-bit words that are written through a small word-wide port.

Byte k of the address, counted in wire order from zero, is compared with `station_addr[8k+7:8k]`. The bytes after the address are let through the input unchanged and have no effect until the next start-of-frame.

Back-pressure rules: `in_ready` is low during reset and high from the first clock after reset, and the filter never stalls the stream. A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. The decision outputs are a one-cycle status pulse with no handshake, and their values hold until the next decision.

Top module: `mac_addr_filter`

## Requirements
- R1: Reset sets both hash table words to zero and clears `dec_valid`. Out of reset, a group address with only the multicast path enabled is rejected and gives `dec_mcast` = 0.
- R2: `in_ready` is 0 while `rst_n` is low and 1 from the first clock after reset. A beat with `in_sof` = 1 is taken as address byte 0 and always restarts address collection, even in the middle of an address.
- R3: `dec_valid` is high for exactly the one cycle after the edge that takes the sixth address byte. Bytes after the sixth, until the next `in_sof`, produce no decision.
- R4: `dec_hash_idx` is bits 31..26 of a CRC-32 with polynomial 0x04C11DB7, seeded with all ones and not inverted at the end. The CRC runs over the address bytes in wire order, bit 0 of each byte first. Each bit computes f = crc[31] XOR d, shifts the CRC left by one, and XORs in the polynomial when f = 1.
- R5: An index of 0..31 selects that bit of table word 0. An index of 32..63 selects bit (index − 32) of word 1. A write with `tbl_wr` = 1 replaces the whole word chosen by `tbl_sel` (0 = low word, 1 = high word) on that clock edge.
- R6: `dec_bcast` = 1 when all 48 address bits are one. `dec_phys` = 1 when the address equals `station_addr`. `dec_mcast` = 1 when bit 0 of byte 0 is set, the address is not broadcast, and the table bit is set. None of these three flags depends on `cfg_mode`.
- R7: `dec_accept` = `cfg_mode[0]` OR (`cfg_mode[1]` AND `dec_phys`) OR (`cfg_mode[2]` AND `dec_mcast`) OR (`cfg_mode[3]` AND `dec_bcast`). Bit 0 is promiscuous, bit 1 own address, bit 2 multicast, bit 3 broadcast. `cfg_mode` is taken on the edge that takes the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte valid |
| in_ready | output | 1 | Filter can take a byte |
| in_sof | input | 1 | Byte is the first byte of a frame |
| in_data | input | 8 | Receive byte |
| cfg_mode | input | 4 | Path enables: 0 promiscuous, 1 own address, 2 multicast, 3 broadcast |
| station_addr | input | 48 | Own address, byte k at bits 8k+7:8k |
| tbl_wr | input | 1 | Hash table word write strobe |
| tbl_sel | input | 1 | Table word select, 0 low, 1 high |
| tbl_wdata | input | 32 | Table word write data |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame is to be kept |
| dec_bcast | output | 1 | Address is broadcast |
| dec_phys | output | 1 | Address equals the station address |
| dec_mcast | output | 1 | Group address with a hash table hit |
| dec_hash_idx | output | 6 | Hash table index of the address |

## Verification
The bench applies several kinds of address:
- Random addresses, whose hash index exposes any error in the bit order, byte order, seed or polynomial of the CRC.
- Copies of the station address, which separate the exact-match path from the others.
- Broadcast against a fully set table, which shows that broadcast never goes through the hash.
- Group addresses against random table contents, which tell the low-word half of the table from the high-word half.

Random enables tell the four gated paths apart. Bursts with idle gaps, trailing payload bytes and a start-of-frame in the middle of an address separate the byte-counting rules from the hash itself.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;
  localparam int CFG_PROMISC = 0;
  localparam int CFG_PHYS    = 1;
  localparam int CFG_MCAST   = 2;
  localparam int CFG_BCAST   = 3;
  localparam int CFG_W       = 4;

  typedef struct packed {
    logic bcast;
    logic phys;
    logic grp;
  } addr_track_t;
endpackage

// File: rtl/mac_filt_crc.sv
module mac_filt_crc #(
  parameter int CRC_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_next,
  output logic [CRC_W-1:0]  crc_q
);
  // one byte per beat, bit 0 first
  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c = restart ? SEED : crc_q;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[CRC_W-1] ^ data[i];
      c = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_next = c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= SEED;
    else if (step) crc_q <= crc_next;
  end

  // R4
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(crc_q));
endmodule

// File: rtl/mac_filt_table.sv
module mac_filt_table #(
  parameter int HASH_BITS = 6,
  parameter int WORD_W = 32,
  localparam int NWORDS = (1 << HASH_BITS) / WORD_W,
  localparam int SEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [SEL_W-1:0]     sel,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [HASH_BITS-1:0] idx,
  output logic                 hit
);
  logic [WORD_W-1:0] words [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr && sel == SEL_W'(w)) q <= wdata;
    end
    assign words[w] = q;

    // R5
    word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_W'(w)) |=> (q == $past(wdata)));
  end

  logic [HASH_BITS-BIT_W-1:0] word_sel;
  logic [BIT_W-1:0]           bit_sel;
  assign word_sel = idx[HASH_BITS-1:BIT_W];
  assign bit_sel  = idx[BIT_W-1:0];
  assign hit = words[word_sel][bit_sel];
endmodule

// File: rtl/mac_filt_match.sv
module mac_filt_match
  import mac_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W = 8,
  parameter int CNT_W = 3,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [CNT_W-1:0]  idx,
  input  logic [BYTE_W-1:0] data,
  input  logic [ADDR_W-1:0] station,
  output addr_track_t       trk_next
);
  addr_track_t       trk_q;
  logic [BYTE_W-1:0] st_byte;

  assign st_byte = station[int'(idx)*BYTE_W +: BYTE_W];

  always_comb begin
    trk_next.phys  = (first ? 1'b1 : trk_q.phys)  & (data == st_byte);
    trk_next.bcast = (first ? 1'b1 : trk_q.bcast) & (&data);
    trk_next.grp   = first ? data[0] : trk_q.grp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trk_q <= '0;
    else if (take) trk_q <= trk_next;
  end

  // R6
  grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !first) |=> (trk_q.grp == $past(trk_q.grp)));
endmodule

// File: rtl/mac_addr_filter.sv
module mac_addr_filter
  import mac_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W = 8,
  parameter int CRC_W = 32,
  parameter int HASH_BITS = 6,
  parameter int TBL_WORD_W = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] CRC_SEED = '1,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W,
  localparam int TBL_WORDS = (1 << HASH_BITS) / TBL_WORD_W,
  localparam int TBL_SEL_W = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_sof,
  input  logic [BYTE_W-1:0]     in_data,
  input  logic [CFG_W-1:0]      cfg_mode,
  input  logic [ADDR_W-1:0]     station_addr,
  input  logic                  tbl_wr,
  input  logic [TBL_SEL_W-1:0]  tbl_sel,
  input  logic [TBL_WORD_W-1:0] tbl_wdata,
  output logic                  dec_valid,
  output logic                  dec_accept,
  output logic                  dec_bcast,
  output logic                  dec_phys,
  output logic                  dec_mcast,
  output logic [HASH_BITS-1:0]  dec_hash_idx
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] IDLE_POS = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

  logic             rdy_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] cur_idx;
  logic             beat, take, first, last;
  logic [CRC_W-1:0] crc_next, crc_q;
  logic [HASH_BITS-1:0] idx_now;
  logic             hit;
  addr_track_t      trk_next;
  logic             mc_now;

  assign in_ready = rdy_q;
  assign beat     = in_valid && rdy_q;
  assign cur_idx  = in_sof ? '0 : pos_q;
  assign take     = beat && (in_sof || pos_q < IDLE_POS);
  assign first    = (cur_idx == '0);
  assign last     = take && (cur_idx == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      pos_q <= IDLE_POS;
    end else begin
      rdy_q <= 1'b1;
      if (take) pos_q <= cur_idx + 1'b1;
    end
  end

  mac_filt_crc #(
    .CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(CRC_POLY), .SEED(CRC_SEED)
  ) u_crc (
    .clk(clk), .rst_n(rst_n), .step(take), .restart(first),
    .data(in_data), .crc_next(crc_next), .crc_q(crc_q)
  );

  assign idx_now = crc_next[CRC_W-1 -: HASH_BITS];

  mac_filt_table #(
    .HASH_BITS(HASH_BITS), .WORD_W(TBL_WORD_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr(tbl_wr), .sel(tbl_sel),
    .wdata(tbl_wdata), .idx(idx_now), .hit(hit)
  );

  mac_filt_match #(
    .ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .idx(cur_idx),
    .data(in_data), .station(station_addr), .trk_next(trk_next)
  );

  assign mc_now = trk_next.grp && !trk_next.bcast && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_accept   <= 1'b0;
      dec_bcast    <= 1'b0;
      dec_phys     <= 1'b0;
      dec_mcast    <= 1'b0;
      dec_hash_idx <= '0;
    end else begin
      dec_valid <= last;
      if (last) begin
        dec_bcast    <= trk_next.bcast;
        dec_phys     <= trk_next.phys;
        dec_mcast    <= mc_now;
        dec_hash_idx <= idx_now;
        dec_accept   <= cfg_mode[CFG_PROMISC]
                      | (cfg_mode[CFG_PHYS]  & trk_next.phys)
                      | (cfg_mode[CFG_MCAST] & mc_now)
                      | (cfg_mode[CFG_BCAST] & trk_next.bcast);
      end
    end
  end

  // R3
  dec_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> dec_valid);
  // R3
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  // R6
  bcast_not_hashed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !(dec_bcast && dec_mcast));
  // R7
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_accept) |-> !$past(cfg_mode[CFG_PROMISC]));
  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
endmodule

// File: tb/mac_addr_filter_tb.sv
module mac_addr_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = '0;
  logic [3:0]  cfg_mode = '0;
  logic [47:0] station_addr = '0;
  logic        tbl_wr = 1'b0;
  logic [0:0]  tbl_sel = '0;
  logic [31:0] tbl_wdata = '0;
  logic        dec_valid, dec_accept, dec_bcast, dec_phys, dec_mcast;
  logic [5:0]  dec_hash_idx;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] m_lo = '0;
  logic [31:0] m_hi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .cfg_mode(cfg_mode),
    .station_addr(station_addr), .tbl_wr(tbl_wr), .tbl_sel(tbl_sel),
    .tbl_wdata(tbl_wdata), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_bcast(dec_bcast), .dec_phys(dec_phys), .dec_mcast(dec_mcast),
    .dec_hash_idx(dec_hash_idx)
  );

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 8; i++) begin
        logic f = c[31] ^ a[8*b + i];
        c = {c[30:0], 1'b0};
        if (f) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic ref_hit(input logic [5:0] ix);
    return (ix < 6'd32) ? m_lo[ix[4:0]] : m_hi[ix[4:0]];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_tbl(input logic sel, input logic [31:0] d);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_sel = sel; tbl_wdata = d;
    @(negedge clk);
    tbl_wr = 1'b0;
    if (sel) m_hi = d; else m_lo = d;
  endtask

  task automatic frame(input logic [47:0] a, input int gap_max, input int trail);
    logic bc, ph, mc, acc;
    logic [5:0] ix;
    for (int b = 0; b < 6; b++) begin
      if (gap_max > 0) begin
        int g = $urandom_range(gap_max, 0);
        for (int k = 0; k < g; k++) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b0;
        end
      end
      @(negedge clk);
      in_valid = 1'b1; in_sof = (b == 0); in_data = a[8*b +: 8];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    ix = ref_hash(a);
    bc = &a;
    ph = (a == station_addr);
    mc = a[0] && !bc && ref_hit(ix);
    acc = cfg_mode[0] | (cfg_mode[1] & ph) | (cfg_mode[2] & mc) | (cfg_mode[3] & bc);
    chk("R3 decision pulse", 32'(dec_valid), 32'd1);
    chk("R4 hash index", 32'(dec_hash_idx), 32'(ix));
    chk("R6 broadcast flag", 32'(dec_bcast), 32'(bc));
    chk("R6 own address flag", 32'(dec_phys), 32'(ph));
    chk("R5 multicast table flag", 32'(dec_mcast), 32'(mc));
    chk("R7 accept", 32'(dec_accept), 32'(acc));
    for (int t = 0; t < trail; t++) begin
      @(negedge clk);
      chk("R3 no decision on payload", 32'(dec_valid), 32'd0);
      in_valid = 1'b1; in_sof = 1'b0; in_data = 8'($urandom);
    end
    if (trail > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk("R3 no decision on payload", 32'(dec_valid), 32'd0);
    end
  endtask

  function automatic logic [47:0] rand_addr();
    return {16'($urandom), 32'($urandom)};
  endfunction

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b;
    void'($urandom(32'd20240613));
    station_addr = 48'h5A_4B_3C_2D_1E_02;
    repeat (3) @(negedge clk);
    chk("R1 no decision in reset", 32'(dec_valid), 32'd0);
    chk("R2 ready low in reset", 32'(in_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready after reset", 32'(in_ready), 32'd1);

    // R1: empty table, multicast path only
    cfg_mode = 4'b0100;
    a = 48'h01_00_00_5E_00_01;
    frame(a, 0, 0);
    chk("R1 empty table rejects group", 32'(dec_accept), 32'd0);

    // R5: set the exact table bit for that address
    if (ref_hash(a) < 6'd32) wr_tbl(1'b0, 32'd1 << ref_hash(a)[4:0]);
    else wr_tbl(1'b1, 32'd1 << ref_hash(a)[4:0]);
    frame(a, 0, 0);
    chk("R5 set bit accepts group", 32'(dec_accept), 32'd1);

    // R5: whole-word replace clears the bit
    wr_tbl(1'b0, 32'd0);
    wr_tbl(1'b1, 32'd0);
    frame(a, 1, 0);
    chk("R5 word rewrite clears hit", 32'(dec_mcast), 32'd0);

    // R6: broadcast never via the hash
    wr_tbl(1'b0, '1);
    wr_tbl(1'b1, '1);
    cfg_mode = 4'b0100;
    frame('1, 0, 2);
    chk("R6 broadcast not multicast", 32'(dec_accept), 32'd0);
    cfg_mode = 4'b1000;
    frame('1, 2, 0);

    // R6/R7: own address, gated by its bit
    cfg_mode = 4'b0000;
    frame(station_addr, 0, 0);
    cfg_mode = 4'b0010;
    frame(station_addr, 2, 3);

    // R2: start-of-frame mid-address restarts
    b = rand_addr();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (k == 0); in_data = b[8*k +: 8];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    chk("R2 no decision on partial address", 32'(dec_valid), 32'd0);
    cfg_mode = 4'b0110;
    frame(rand_addr(), 0, 0);

    // R7: promiscuous
    cfg_mode = 4'b0001;
    for (int k = 0; k < 8; k++) frame(rand_addr(), 1, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin
        wr_tbl(1'b0, $urandom);
        wr_tbl(1'b1, $urandom);
        station_addr = rand_addr() & ~48'h1;
      end
      cfg_mode = 4'($urandom);
      case ($urandom_range(3, 0))
        0: a = rand_addr();
        1: a = station_addr;
        2: a = '1;
        default: a = rand_addr() | 48'h1;
      endcase
      frame(a, $urandom_range(2, 0), $urandom_range(3, 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule